// File: doc/BRIEF.md
# Connection Data Fetch and Cell Header Rewrite

This block sits behind a connection lookup in a cell switch port. For each lookup result it receives a region bit, a 12-bit entry index and a match kind, together with the 32-bit header of the cell that caused the lookup. On a hit it reads the connection's 128 bits of stored data as four 32-bit words. The reads go out on four consecutive cycles through a synchronous memory port that returns data one cycle after the address. The block then emits the cell header with its path and channel identifiers replaced, its loss-priority bit raised when the stored data asks for it, and a 64-bit routing tag that travels in front of the cell.

The memory address is the region bit, then the entry index, then a 2-bit word counter. Region 0 holds full-connection data and region 1 holds path-only data, and each region is 16K words. A lookup takes four cycles, so a new lookup may be accepted in the same cycle that the last word of the previous fetch is addressed. The fetch of one connection therefore overlaps the next lookup. Cells whose lookup missed, or whose stored data carries a drop flag, produce no output.

Top module: `adx_hdr_rewrite`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_rd_en` and `out_valid` are 0.
- R2: A hit lookup (kind 2'b01 full, or 2'b10 path-only) sampled at a clock edge yields `mem_rd_en` high for exactly the next four cycles. The low two address bits step 0, 1, 2, 3 and the upper bits equal {region bit, entry index}.
- R3: The region bit is address bit 14, so region 1 reads fall in 0x4000–0x7FFF and region 0 reads fall in 0x0000–0x3FFF.
- R4: A lookup of kind 2'b00 (miss) or 2'b11 (reserved) issues no memory read and produces no output.
- R5: On a full match, output header bits [31:20] (path id) take word 0 bits [31:20], and bits [19:4] (channel id) take word 0 bits [19:4]. Header bits [3:1] pass through unchanged.
- R6: On a path-only match, only header bits [31:20] are replaced, and bits [19:4] keep the incoming channel id.
- R7: Output header bit 0 (loss priority) is the incoming bit 0 OR word 1 bit 0. A set bit is never cleared.
- R8: When word 1 bit 1 is set, all four reads still happen, but no output is produced for that cell.
- R9: The output is a one-cycle `out_valid` pulse five clock edges after the lookup edge, with `out_tag` = {word 2, word 3}.
- R10: Hit lookups spaced four cycles apart are each fetched and rewritten with their own header. A hit lookup must not arrive while an earlier fetch still has words other than the last to address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup result valid this cycle |
| lk_page | input | 1 | Region bit of the lookup result |
| lk_entry | input | 12 | Matching entry index |
| lk_kind | input | 2 | 00 miss, 01 full match, 10 path-only match, 11 reserved |
| hdr_in | input | 32 | Cell header belonging to the lookup |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory word address {region, entry, word} |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |
| out_valid | output | 1 | Rewritten header and tag valid |
| out_hdr | output | 32 | Rewritten cell header |
| out_tag | output | 64 | Routing tag to prepend |

## Verification
Single lookups are driven with full matches, path-only matches, misses and the reserved kind, in both regions and at the lowest, highest and mid-range entry indices. Each case separates full from path-only replacement and separates the two regions by address bit 14. Stored control words are varied so that loss-priority forcing, loss-priority pass-through of an already set bit, and dropping are each observed apart from one another. A back-to-back pair spaced at the minimum four cycles shows that overlapped fetches keep each cell's own header. A reset in the middle of a fetch shows that pending reads and output are abandoned.

// File: rtl/adx_pkg.sv
// Shared types and field positions for the connection data fetch and header
// rewrite block. Assumes a 32-bit cell header laid out as path id [31:20],
// channel id [19:4], payload type [3:1], loss priority [0].
package adx_pkg;

    localparam int HDR_W        = 32;
    localparam int VPI_W        = 12;
    localparam int VCI_W        = 16;
    localparam int VPI_LSB      = 20;
    localparam int VCI_LSB      = 4;
    localparam int CLP_BIT      = 0;
    localparam int CTL_CLP_BIT  = 0;
    localparam int CTL_DROP_BIT = 1;

    typedef enum logic [1:0] {
        MT_NONE = 2'b00,
        MT_FULL = 2'b01,
        MT_PATH = 2'b10,
        MT_RSVD = 2'b11
    } match_t;

    // True for the two match kinds that need a data fetch.
    function automatic logic is_hit(input match_t kind);
        return (kind == MT_FULL) || (kind == MT_PATH);
    endfunction

    // Builds the outgoing header from the incoming one and the stored fields.
    function automatic logic [HDR_W-1:0] rewrite_hdr(
        input match_t             kind,
        input logic [HDR_W-1:0]   hdr,
        input logic [VPI_W-1:0]   vpi,
        input logic [VCI_W-1:0]   vci,
        input logic               set_clp
    );
        logic [HDR_W-1:0] r;
        r = hdr;
        r[VPI_LSB +: VPI_W] = vpi;
        if (kind == MT_FULL) begin
            r[VCI_LSB +: VCI_W] = vci;
        end
        r[CLP_BIT] = hdr[CLP_BIT] | set_clp;
        return r;
    endfunction

endpackage

// File: rtl/adx_fetch_seq.sv
// Read sequencer: accepts hit lookups and issues WORDS consecutive reads at
// {region, entry, word}. It also delays the read strobe and word index by the
// one-cycle latency of the memory so they line up with returning data.
// Assumes hit lookups arrive no closer than WORDS cycles apart; a new hit may
// be accepted in the cycle the last word is addressed.
module adx_fetch_seq
    import adx_pkg::*;
#(
    parameter  int ENTRY_W = 12,
    parameter  int WORDS   = 4,
    localparam int CNT_W   = $clog2(WORDS),
    localparam int ADDR_W  = 1 + ENTRY_W + CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic                lk_page,
    input  logic [ENTRY_W-1:0]  lk_entry,
    input  logic [1:0]          lk_kind,
    input  logic [HDR_W-1:0]    hdr_in,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                rsp_vld,
    output logic [CNT_W-1:0]    rsp_idx,
    output match_t              ctx_kind,
    output logic [HDR_W-1:0]    ctx_hdr
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    logic               active;
    logic [CNT_W-1:0]   cnt;
    logic [ENTRY_W:0]   base;
    logic               accept;

    // A hit is taken when idle or while the last word is being addressed.
    assign accept = lk_valid && is_hit(match_t'(lk_kind)) && (!active || cnt == LAST);

    // Word counter and captured lookup context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            base     <= '0;
            ctx_kind <= MT_NONE;
            ctx_hdr  <= '0;
        end else if (accept) begin
            active   <= 1'b1;
            cnt      <= '0;
            base     <= {lk_page, lk_entry};
            ctx_kind <= match_t'(lk_kind);
            ctx_hdr  <= hdr_in;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign mem_rd_en = active;
    assign mem_addr  = {base, cnt};

    // Tracks the memory latency so the assembler knows which word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld <= 1'b0;
            rsp_idx <= '0;
        end else begin
            rsp_vld <= active;
            rsp_idx <= cnt;
        end
    end

    // A hit starts a fetch at word 0 of its own entry next cycle.
    assert_fetch_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && is_hit(match_t'(lk_kind)) && (!mem_rd_en || mem_addr[CNT_W-1:0] == LAST))
        |=> (mem_rd_en && mem_addr[CNT_W-1:0] == '0
             && mem_addr[ADDR_W-1:CNT_W] == $past({lk_page, lk_entry})));

    // Words are addressed back to back with no gap.
    assert_word_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_addr[CNT_W-1:0] != LAST)
        |=> (mem_rd_en && mem_addr == $past(mem_addr) + 1'b1));

    // A miss or reserved kind while idle leaves the memory untouched.
    assert_miss_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !is_hit(match_t'(lk_kind)) && !mem_rd_en) |=> !mem_rd_en);

    // Input contract on spacing of hit lookups.
    assert_lookup_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && is_hit(match_t'(lk_kind))) |-> (!mem_rd_en || mem_addr[CNT_W-1:0] == LAST));

endmodule

// File: rtl/adx_assemble.sv
// Response assembler: collects the returning words of one fetch, keeps the
// cell context from the first word onward, and on the last word registers
// the rewritten header and routing tag unless the drop flag was stored.
// Assumes word 0 holds new ids, word 1 control flags, words 2.. the tag.
module adx_assemble
    import adx_pkg::*;
#(
    parameter  int WORD_W = 32,
    parameter  int WORDS  = 4,
    localparam int CNT_W  = $clog2(WORDS),
    localparam int TAG_W  = (WORDS - 2) * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rsp_vld,
    input  logic [CNT_W-1:0]    rsp_idx,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  match_t              ctx_kind,
    input  logic [HDR_W-1:0]    ctx_hdr,
    output logic                out_valid,
    output logic [HDR_W-1:0]    out_hdr,
    output logic [TAG_W-1:0]    out_tag
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    match_t                     a_kind;
    logic [HDR_W-1:0]           a_hdr;
    logic [VPI_W-1:0]           a_vpi;
    logic [VCI_W-1:0]           a_vci;
    logic                       a_setclp;
    logic                       a_drop;
    logic [TAG_W-1:0]           tag_acc;
    logic [TAG_W+WORD_W-1:0]    tag_cat;
    logic [TAG_W-1:0]           tag_nxt;
    logic                       unused_bits;

    // Tag words shift in oldest-first so word 2 ends in the top bits.
    assign tag_cat     = {tag_acc, mem_rdata};
    assign tag_nxt     = tag_cat[TAG_W-1:0];
    assign unused_bits = ^{mem_rdata, tag_cat[TAG_W+WORD_W-1:TAG_W]};

    // Per-word capture and final output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_kind    <= MT_NONE;
            a_hdr     <= '0;
            a_vpi     <= '0;
            a_vci     <= '0;
            a_setclp  <= 1'b0;
            a_drop    <= 1'b0;
            tag_acc   <= '0;
            out_valid <= 1'b0;
            out_hdr   <= '0;
            out_tag   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (rsp_vld) begin
                if (rsp_idx == '0) begin
                    a_kind <= ctx_kind;
                    a_hdr  <= ctx_hdr;
                    a_vpi  <= mem_rdata[VPI_LSB +: VPI_W];
                    a_vci  <= mem_rdata[VCI_LSB +: VCI_W];
                end else if (rsp_idx == CNT_W'(1)) begin
                    a_setclp <= mem_rdata[CTL_CLP_BIT];
                    a_drop   <= mem_rdata[CTL_DROP_BIT];
                end else begin
                    tag_acc <= tag_nxt;
                end
                if (rsp_idx == LAST) begin
                    out_valid <= !a_drop;
                    out_hdr   <= rewrite_hdr(a_kind, a_hdr, a_vpi, a_vci, a_setclp);
                    out_tag   <= tag_nxt;
                end
            end
        end
    end

    // One output pulse per cell; spacing keeps pulses apart.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // A loss-priority bit already set on the way in survives the rewrite.
    assert_clp_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hdr[CLP_BIT] || !$past(a_hdr[CLP_BIT])));

    // Path-only matches keep the incoming channel id.
    assert_vci_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(a_kind) == MT_PATH)
        |-> (out_hdr[VCI_LSB +: VCI_W] == $past(a_hdr[VCI_LSB +: VCI_W])));

endmodule

// File: rtl/adx_hdr_rewrite.sv
// Top of the connection data fetch and header rewrite block. Wires the read
// sequencer to the response assembler. Assumes a memory with one-cycle
// synchronous read latency on mem_addr/mem_rd_en -> mem_rdata.
module adx_hdr_rewrite
    import adx_pkg::*;
#(
    parameter  int ENTRY_W = 12,
    parameter  int WORD_W  = 32,
    parameter  int WORDS   = 4,
    localparam int CNT_W   = $clog2(WORDS),
    localparam int ADDR_W  = 1 + ENTRY_W + CNT_W,
    localparam int TAG_W   = (WORDS - 2) * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic                lk_page,
    input  logic [ENTRY_W-1:0]  lk_entry,
    input  logic [1:0]          lk_kind,
    input  logic [HDR_W-1:0]    hdr_in,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                out_valid,
    output logic [HDR_W-1:0]    out_hdr,
    output logic [TAG_W-1:0]    out_tag
);

    logic               rsp_vld;
    logic [CNT_W-1:0]   rsp_idx;
    match_t             ctx_kind;
    logic [HDR_W-1:0]   ctx_hdr;

    adx_fetch_seq #(
        .ENTRY_W (ENTRY_W),
        .WORDS   (WORDS)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_page   (lk_page),
        .lk_entry  (lk_entry),
        .lk_kind   (lk_kind),
        .hdr_in    (hdr_in),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .rsp_vld   (rsp_vld),
        .rsp_idx   (rsp_idx),
        .ctx_kind  (ctx_kind),
        .ctx_hdr   (ctx_hdr)
    );

    adx_assemble #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_vld   (rsp_vld),
        .rsp_idx   (rsp_idx),
        .mem_rdata (mem_rdata),
        .ctx_kind  (ctx_kind),
        .ctx_hdr   (ctx_hdr),
        .out_valid (out_valid),
        .out_hdr   (out_hdr),
        .out_tag   (out_tag)
    );

endmodule

// File: tb/test_adx_hdr_rewrite.sv
// Bench for the fetch and rewrite block: a vector table of single lookups,
// then directed tests for reset, overlapped lookups and mid-fetch reset.
module test_adx_hdr_rewrite;

    typedef struct packed {
        logic [1:0]  kind;
        logic        page;
        logic [11:0] ent;
        logic [31:0] hdr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 1'b0, 12'h010, 32'h1234_5678},
        '{2'b01, 1'b0, 12'h011, 32'hABCD_E0F0},
        '{2'b10, 1'b1, 12'h022, 32'h00FF_FFF1},
        '{2'b10, 1'b1, 12'hFFF, 32'h5555_AAA0},
        '{2'b00, 1'b0, 12'h123, 32'h0F0F_0F0F},
        '{2'b11, 1'b1, 12'h456, 32'hF0F0_F0F0},
        '{2'b01, 1'b1, 12'hFFE, 32'h8765_4321},
        '{2'b01, 1'b0, 12'h000, 32'hFFFF_FFFF},
        '{2'b10, 1'b1, 12'h800, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_page = 1'b0;
    logic [11:0] lk_entry = '0;
    logic [1:0]  lk_kind = '0;
    logic [31:0] hdr_in = '0;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        out_valid;
    logic [31:0] out_hdr;
    logic [63:0] out_tag;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adx_hdr_rewrite i_adx_hdr_rewrite (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_page   (lk_page),
        .lk_entry  (lk_entry),
        .lk_kind   (lk_kind),
        .hdr_in    (hdr_in),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .out_valid (out_valid),
        .out_hdr   (out_hdr),
        .out_tag   (out_tag)
    );

    // Stored word contents, computed from the address.
    function automatic logic [31:0] memf(input logic [14:0] a);
        logic        pg = a[14];
        logic [11:0] e  = a[13:2];
        case (a[1:0])
            2'd0:    return {e ^ 12'h3C5, {e, pg, 3'b101} ^ 16'h9E37, 4'b0110};
            2'd1:    return {e, pg, 17'h1F0F0, &e[3:1], e[0]};
            2'd2:    return {4'hA, 3'b000, pg, 12'h000, e};
            default: return ~{4'hA, 3'b000, pg, 12'h000, e};
        endcase
    endfunction

    // Synchronous memory model with one cycle of read latency.
    always_ff @(posedge clk) begin
        mem_rdata <= mem_rd_en ? memf(mem_addr) : 32'h0;
    end

    function automatic logic [31:0] exp_hdr(input vec_t v);
        logic [31:0] w0 = memf({v.page, v.ent, 2'd0});
        logic [31:0] w1 = memf({v.page, v.ent, 2'd1});
        logic [31:0] r  = v.hdr;
        r[31:20] = w0[31:20];
        if (v.kind == 2'b01) r[19:4] = w0[19:4];
        r[0] = v.hdr[0] | w1[0];
        return r;
    endfunction

    function automatic logic [63:0] exp_tag(input vec_t v);
        return {memf({v.page, v.ent, 2'd2}), memf({v.page, v.ent, 2'd3})};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic drive(input vec_t v);
        lk_valid = 1'b1;
        lk_kind  = v.kind;
        lk_page  = v.page;
        lk_entry = v.ent;
        hdr_in   = v.hdr;
    endtask

    task automatic check_out(input vec_t v);
        logic hit  = (v.kind == 2'b01) || (v.kind == 2'b10);
        logic drop = memf({v.page, v.ent, 2'd1})[1];
        logic [31:0] eh = exp_hdr(v);
        check(hit ? (drop ? "R8 drop" : "R9 valid") : "R4 no output",
              64'(out_valid), 64'(hit && !drop));
        if (hit && !drop) begin
            check(v.kind == 2'b01 ? "R5 full ids" : "R6 path id only",
                  64'(out_hdr[31:1]), 64'(eh[31:1]));
            check("R7 loss priority", 64'(out_hdr[0]), 64'(eh[0]));
            check("R9 tag", out_tag, exp_tag(v));
        end
    endtask

    // One lookup, its reads on the next four cycles, output five edges later.
    task automatic run_one(input vec_t v);
        logic hit = (v.kind == 2'b01) || (v.kind == 2'b10);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        lk_valid = 1'b0;
        for (int w = 0; w < 4; w++) begin
            if (w > 0) @(negedge clk);
            if (hit) begin
                check("R2 read strobe", 64'(mem_rd_en), 64'd1);
                check("R2 R3 read address", 64'(mem_addr), 64'({v.page, v.ent, 2'(w)}));
            end else begin
                check("R4 no read", 64'(mem_rd_en), 64'd0);
            end
        end
        @(negedge clk);
        check("R2 reads end", 64'(mem_rd_en), 64'd0);
        check("R9 not early", 64'(out_valid), 64'd0);
        @(negedge clk);
        check_out(v);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 read idle in reset", 64'(mem_rd_en), 64'd0);
        check("R1 output idle in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 read idle after reset", 64'(mem_rd_en), 64'd0);
        check("R1 output idle after reset", 64'(out_valid), 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i]);
        end

        // R10: two hits four cycles apart
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (3) @(negedge clk);
        drive(VECS[2]);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R10 second fetch starts", 64'(mem_rd_en), 64'd1);
        check("R10 second fetch address", 64'(mem_addr), 64'({VECS[2].page, VECS[2].ent, 2'd0}));
        @(negedge clk);
        check_out(VECS[0]);
        check("R10 first header kept", 64'(out_hdr), 64'(exp_hdr(VECS[0])));
        repeat (3) begin
            @(negedge clk);
            check("R10 gap between outputs", 64'(out_valid), 64'd0);
        end
        @(negedge clk);
        check_out(VECS[2]);
        check("R10 second header kept", 64'(out_hdr), 64'(exp_hdr(VECS[2])));

        // R1: reset in the middle of a fetch abandons it
        @(negedge clk);
        drive(VECS[1]);
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset stops reads", 64'(mem_rd_en), 64'd0);
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check("R1 no output after reset", 64'(out_valid), 64'd0);
            check("R1 no read after reset", 64'(mem_rd_en), 64'd0);
        end

        report();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

endmodule